// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator with Timer Clock Selection

This block holds a 16-bit counter fed by a single input pin. In event mode it adds one for every edge of the chosen polarity on the pin. In gated mode it adds one for every divide-by-64 system clock strobe that arrives while the pin is at its active level, but only while the main timer is running. In both modes it has an overflow flag and an input-edge flag. Each flag is cleared by writing 1 to its bit. An optional fast-clear mode clears both flags on any access to the counter. Each flag has its own interrupt enable.

Each counting event is also a strobe of the accumulator clock. A free-running 16-bit prescale counter advances on every such strobe and provides taps at divide-by-256 and divide-by-65536. A four-way selector chooses the single-cycle enable that drives the main timer counter. The choices are the timer prescaler strobe, the accumulator clock, or one of the two taps. The pin passes through a two-stage synchroniser before edges are detected, so a pin change reaches the counter on the third rising clock edge after it.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register (address 0), flag register (address 1) and counter (address 2) read 0, and irq_o is 0. Control bits are: bit 0 accumulator on, bit 1 gated mode, bit 2 edge select, bit 3 overflow interrupt enable, bit 4 edge interrupt enable, bits 6:5 timer clock select, bit 7 fast clear. Flag bits are: bit 1 overflow, bit 0 edge.
- R2: In event mode with edge select 0, each falling edge of the pin adds one to the counter and sets the edge flag. Rising edges are not counted.
- R3: In event mode with edge select 1, each rising edge adds one and sets the edge flag. Falling edges are not counted.
- R4: In gated mode with edge select 0, each divide-by-64 strobe taken while the pin is high adds one. The falling edge of the pin sets the edge flag.
- R5: In gated mode with edge select 1, strobes taken while the pin is low add one. The rising edge of the pin sets the edge flag.
- R6: While timer_on_i is 0, gated mode does not count.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. A write to the counter address loads the counter.
- R8: A write to the flag address clears the overflow flag when data bit 1 is 1 and the edge flag when data bit 0 is 1. Bits written as 0 leave their flags unchanged.
- R9: With fast clear set, any read or write of the counter address clears both flags. With fast clear off, reading the counter leaves both flags unchanged.
- R10: irq_o is 1 exactly when some flag is set and its enable bit is 1.
- R11: When the accumulator is on, tmr_clk_stb_o follows the timer clock select: 00 gives presc_stb_i, 01 gives one strobe per accumulator event, 10 gives one strobe per 256 events, and 11 gives one strobe per 65536 events.
- R12: With the accumulator off, tmr_clk_stb_o equals presc_stb_i whatever the select bits hold, and the counter and edge flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| div64_stb_i | input | 1 | Divide-by-64 system clock enable strobe |
| timer_on_i | input | 1 | Main timer running |
| presc_stb_i | input | 1 | Timer prescaler clock enable strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from the address) |
| irq_o | output | 1 | Interrupt request |
| tmr_clk_stb_o | output | 1 | Enable strobe for the main timer counter |

## Verification
A wrong counter value or a lost wrap shows up on the next counter read. A stuck or wrongly cleared flag shows up at once on irq_o and on a flag read in the cycle after the access that should have changed it. A fault in the prescale counter or the selector shows up only in the strobe count on tmr_clk_stb_o over a window of 256 or 65536 events. For that reason the bench runs full windows instead of sampling single cycles.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

    typedef enum logic [1:0] {
        SEL_PRESC  = 2'b00,
        SEL_ACCCLK = 2'b01,
        SEL_DIV8   = 2'b10,
        SEL_DIV16  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic       fast_clr;
        logic [1:0] clk_sel;
        logic       edge_ie;
        logic       ovf_ie;
        logic       edge_sel;
        logic       gated;
        logic       acc_on;
    } pa_ctrl_t;

    typedef struct packed {
        pa_ctrl_t           ctrl;
        logic [CNT_W-1:0]   cnt;
        logic               ovf;
        logic               edg;
    } pa_state_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = sync_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~sync_q[STAGES-1] & prev_q;

    // R2 / R3: an edge is reported for a single cycle only
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
    parameter int W     = 16,
    parameter int LOW_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic tap_low_o,
    output logic tap_full_o
);
    logic [W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (tick_i) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tap_low_o  = tick_i & (&pre_q[LOW_W-1:0]);
    assign tap_full_o = tick_i & (&pre_q);

    // R11: the low tap cannot fire in two consecutive cycles
    a_r11_tap_low_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tap_low_o |=> !tap_low_o);
endmodule

// File: rtl/pa_clkmux.sv
module pa_clkmux
    import pa_pkg::*;
(
    input  logic     acc_on_i,
    input  clk_sel_e sel_i,
    input  logic     presc_i,
    input  logic     accclk_i,
    input  logic     tap_low_i,
    input  logic     tap_full_i,
    output logic     stb_o
);
    always_comb begin
        stb_o = presc_i;
        if (acc_on_i) begin
            unique case (sel_i)
                SEL_PRESC:  stb_o = presc_i;
                SEL_ACCCLK: stb_o = accclk_i;
                SEL_DIV8:   stb_o = tap_low_i;
                SEL_DIV16:  stb_o = tap_full_i;
                default:    stb_o = presc_i;
            endcase
        end
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              div64_stb_i,
    input  logic              timer_on_i,
    input  logic              presc_stb_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              tmr_clk_stb_o
);
    pa_state_t st_d, st_q;

    logic pin_lvl, pin_rise, pin_fall;
    logic sel_edge, gate_act, acc_clk, edge_hit, cnt_wrap, cnt_access;
    logic tap_low, tap_full;

    pa_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    always_comb begin
        sel_edge   = st_q.ctrl.edge_sel ? pin_rise : pin_fall;
        gate_act   = st_q.ctrl.edge_sel ? ~pin_lvl : pin_lvl;
        acc_clk    = st_q.ctrl.acc_on &
                     (st_q.ctrl.gated ? (div64_stb_i & timer_on_i & gate_act) : sel_edge);
        edge_hit   = st_q.ctrl.acc_on & sel_edge;
        cnt_wrap   = acc_clk & (&st_q.cnt);
        cnt_access = (reg_wr_i | reg_rd_i) & (reg_addr_i == ADDR_CNT);
    end

    pa_prescale #(.W(CNT_W), .LOW_W(CNT_W/2)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (acc_clk),
        .tap_low_o  (tap_low),
        .tap_full_o (tap_full)
    );

    pa_clkmux u_mux (
        .acc_on_i   (st_q.ctrl.acc_on),
        .sel_i      (clk_sel_e'(st_q.ctrl.clk_sel)),
        .presc_i    (presc_stb_i),
        .accclk_i   (acc_clk),
        .tap_low_i  (tap_low),
        .tap_full_i (tap_full),
        .stb_o      (tmr_clk_stb_o)
    );

    always_comb begin
        st_d = st_q;
        if (acc_clk) st_d.cnt = st_q.cnt + 1'b1;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADDR_CTRL: st_d.ctrl = pa_ctrl_t'(reg_wdata_i[7:0]);
                ADDR_FLAG: begin
                    if (reg_wdata_i[1]) st_d.ovf = 1'b0;
                    if (reg_wdata_i[0]) st_d.edg = 1'b0;
                end
                ADDR_CNT:  st_d.cnt = reg_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        if (st_q.ctrl.fast_clr && cnt_access) begin
            st_d.ovf = 1'b0;
            st_d.edg = 1'b0;
        end
        if (cnt_wrap) st_d.ovf = 1'b1;
        if (edge_hit) st_d.edg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CTRL: reg_rdata_o[7:0] = st_q.ctrl;
            ADDR_FLAG: reg_rdata_o[1:0] = {st_q.ovf, st_q.edg};
            ADDR_CNT:  reg_rdata_o      = st_q.cnt;
            default:   reg_rdata_o      = '0;
        endcase
    end

    assign irq_o = (st_q.ovf & st_q.ctrl.ovf_ie) | (st_q.edg & st_q.ctrl.edge_ie);

    // R7: a wrap of the counter lands on zero with the overflow flag set
    a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wrap && !(reg_wr_i && reg_addr_i == ADDR_CNT)) |=> (st_q.cnt == '0 && st_q.ovf));
    // R10: no request without a pending flag
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.ovf || st_q.edg));
    // R8: a write-one to the overflow bit clears it unless a wrap coincides
    a_r8_ovf_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_FLAG && reg_wdata_i[1] && !cnt_wrap) |=> !st_q.ovf);
    // R9: counter access under fast clear empties both flags
    a_r9_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_access && st_q.ctrl.fast_clr && !cnt_wrap && !edge_hit) |=> (!st_q.ovf && !st_q.edg));
    // R6: gated mode with the timer stopped holds the counter
    a_r6_idle_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.gated && !timer_on_i && !(reg_wr_i && reg_addr_i == ADDR_CNT)) |=> $stable(st_q.cnt));
    // R12: with the accumulator off the timer sees only the prescaler
    a_r12_presc_only: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.acc_on |-> (tmr_clk_stb_o == presc_stb_i));
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_i = 1'b0;
    logic        div64_stb_i = 1'b0;
    logic        timer_on_i = 1'b1;
    logic        presc_stb_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [15:0] reg_wdata_i = 16'd0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;
    logic        tmr_clk_stb_o;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_accum dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .div64_stb_i(div64_stb_i),
        .timer_on_i(timer_on_i), .presc_stb_i(presc_stb_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .tmr_clk_stb_o(tmr_clk_stb_o)
    );

    always @(posedge clk) if (tmr_clk_stb_o) stb_cnt++;

    localparam logic [1:0] A_CTRL = 2'd0, A_FLAG = 2'd1, A_CNT = 2'd2;

    // {ctrl, full pulses, end high, expected count}
    localparam logic [39:0] VEC [4] = '{
        {8'h01, 8'd3, 8'd1, 16'd3},
        {8'h05, 8'd3, 8'd1, 16'd4},
        {8'h05, 8'd2, 8'd0, 16'd2},
        {8'h00, 8'd3, 8'd1, 16'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        #1 d = int'(reg_rdata_o);
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic setpin(input logic v);
        @(negedge clk);
        pin_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic divs(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) div64_stb_i = 1'b1;
            @(negedge clk) div64_stb_i = 1'b0;
        end
    endtask

    task automatic hold_div(input int k);
        @(negedge clk) div64_stb_i = 1'b1;
        repeat (k) @(negedge clk);
        div64_stb_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int v;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_FLAG, v); chk("R1 flags", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        chk("R1 irq", irq_o, 0);

        // R2 / R3 / R12 event-mode table
        foreach (VEC[i]) begin
            wr(A_CNT, 16'd0);
            wr(A_FLAG, 16'd3);
            wr(A_CTRL, {8'd0, VEC[i][39:32]});
            for (int p = 0; p < int'(VEC[i][31:24]); p++) begin
                setpin(1'b1);
                setpin(1'b0);
            end
            if (VEC[i][16]) setpin(1'b1);
            rd(A_CNT, v);  chk("R2/R3/R12 count", v, int'(VEC[i][15:0]));
            rd(A_FLAG, v); chk("R2/R3/R12 edge flag", v & 1, (VEC[i][15:0] != 0) ? 1 : 0);
            wr(A_CTRL, 16'd0);
            setpin(1'b0);
        end

        // R4 gated, high level active, falling edge flags
        wr(A_CNT, 16'd0); wr(A_FLAG, 16'd3);
        setpin(1'b1);
        wr(A_CTRL, 16'h0003);
        divs(5);
        setpin(1'b0);
        divs(3);
        rd(A_CNT, v);  chk("R4 gated count", v, 5);
        rd(A_FLAG, v); chk("R4 trailing edge flag", v, 1);
        // R6 timer stopped
        timer_on_i = 1'b0;
        setpin(1'b1);
        divs(3);
        rd(A_CNT, v);  chk("R6 no count with timer off", v, 5);
        timer_on_i = 1'b1;

        // R5 gated, low level active, rising edge flags
        wr(A_CTRL, 16'h0000);
        setpin(1'b0);
        wr(A_CNT, 16'd0); wr(A_FLAG, 16'd3);
        wr(A_CTRL, 16'h0007);
        divs(4);
        rd(A_FLAG, v); chk("R5 no flag before trailing edge", v, 0);
        setpin(1'b1);
        divs(2);
        rd(A_CNT, v);  chk("R5 gated count", v, 4);
        rd(A_FLAG, v); chk("R5 trailing edge flag", v, 1);

        // R7 overflow
        wr(A_CTRL, 16'h0000);
        setpin(1'b0);
        wr(A_FLAG, 16'd3);
        wr(A_CNT, 16'hFFFE);
        wr(A_CTRL, 16'h0005);
        setpin(1'b1); setpin(1'b0); setpin(1'b1);
        rd(A_CNT, v);  chk("R7 wrap to zero", v, 0);
        rd(A_FLAG, v); chk("R7 overflow flag", v, 3);
        // R10 interrupt enables
        chk("R10 irq off without enables", irq_o, 0);
        wr(A_CTRL, 16'h000D);
        chk("R10 irq from overflow", irq_o, 1);
        wr(A_CTRL, 16'h0015);
        chk("R10 irq from edge", irq_o, 1);
        // R8 write one to clear
        wr(A_FLAG, 16'd0);
        rd(A_FLAG, v); chk("R8 zero write keeps flags", v, 3);
        wr(A_FLAG, 16'd1);
        rd(A_FLAG, v); chk("R8 bit0 clears edge only", v, 2);
        chk("R10 irq drops with edge flag", irq_o, 0);
        wr(A_FLAG, 16'd2);
        rd(A_FLAG, v); chk("R8 bit1 clears overflow", v, 0);

        // R9 fast clear
        setpin(1'b0); setpin(1'b1);
        wr(A_CNT, 16'hFFFF);
        setpin(1'b0); setpin(1'b1);
        rd(A_FLAG, v); chk("R9 flags set", v, 3);
        rd(A_CNT, v);
        rd(A_FLAG, v); chk("R9 read without fast clear keeps", v, 3);
        wr(A_CTRL, 16'h0085);
        rd(A_CNT, v);
        rd(A_FLAG, v); chk("R9 counter read clears", v, 0);
        setpin(1'b0); setpin(1'b1);
        rd(A_FLAG, v); chk("R9 edge set again", v, 1);
        wr(A_CNT, 16'd5);
        rd(A_FLAG, v); chk("R9 counter write clears", v, 0);

        // R11 clock selection
        wr(A_CTRL, 16'h0025);
        setpin(1'b0);
        s0 = stb_cnt;
        for (int p = 0; p < 3; p++) begin setpin(1'b1); setpin(1'b0); end
        chk("R11 sel 01 accumulator clock", stb_cnt - s0, 3);
        wr(A_CTRL, 16'h0005);
        s0 = stb_cnt;
        @(negedge clk) presc_stb_i = 1'b1;
        repeat (7) @(negedge clk);
        presc_stb_i = 1'b0;
        chk("R11 sel 00 prescaler", stb_cnt - s0, 7);
        // R12 accumulator off ignores select
        wr(A_CTRL, 16'h0024);
        s0 = stb_cnt;
        @(negedge clk) presc_stb_i = 1'b1;
        repeat (4) @(negedge clk);
        presc_stb_i = 1'b0;
        setpin(1'b1); setpin(1'b0); setpin(1'b1);
        chk("R12 prescaler only when off", stb_cnt - s0, 4);
        // R11 divided taps over full windows (gated, high active)
        wr(A_CTRL, 16'h0043);
        s0 = stb_cnt;
        hold_div(512);
        chk("R11 sel 10 one per 256", stb_cnt - s0, 2);
        wr(A_CTRL, 16'h0063);
        s0 = stb_cnt;
        hold_div(65536);
        chk("R11 sel 11 one per 65536", stb_cnt - s0, 1);

        finish_run();
    end
endmodule